// File: doc/BRIEF.md
# Page-Buffered Serial Write Controller

This block sits behind the command decoder of a serial memory and handles the page-program path. The decoder hands it every received byte and pulses a strobe when chip select goes inactive, together with a flag that tells whether the bit count at that moment was a whole number of bytes. The block checks the opcode byte and the write-enable latch, gathers a three-byte address, and loads the data bytes into a one-page staging buffer. If the frame closes cleanly, it copies the staged bytes into the array and then holds the write-in-progress flag high for a programmable number of clock ticks.

The controller is a single state machine with six states. `ST_IDLE` waits for the first byte of a frame. An accepted write opcode moves it to `ST_ADDR`, and any other first byte moves it to `ST_SKIP`. After the third address byte it goes from `ST_ADDR` to `ST_DATA`. A frame end in `ST_ADDR`, `ST_DATA` or `ST_SKIP` returns it to `ST_IDLE`, except that a clean end in `ST_DATA` moves it to `ST_COMMIT`. `ST_COMMIT` walks every buffer slot once and then enters `ST_BUSY`. When the tick timer expires, `ST_BUSY` returns to `ST_IDLE`, or to `ST_SKIP` if a frame is still open at that moment.

A staging slot counts as loaded only if the current frame wrote it. When a commit happens, the array receives just those slots and the rest of the page is left untouched.

Top module: `pgw_top`

## Requirements
- R1: During and just after reset, `wip`, `arr_we` and `wel_clr` are all 0.
- R2: A write frame begins with the opcode byte 0x02, followed by three address bytes sent most significant first. Only the low 17 bits of the resulting 24-bit address are used: bits 16..8 select the page and bits 7..0 give the starting offset.
- R3: Each data byte goes into the staging slot at the current offset, and the offset then increases by one modulo 256 inside the same page. When a later byte lands on an offset that already holds a byte, the later byte replaces the earlier one.
- R4: A commit needs `frm_end` with `frm_aligned`=1 in `ST_DATA` and at least one loaded byte. A frame that ends unaligned, during the address bytes, or with no data bytes writes nothing, and `wip` stays 0.
- R5: If `wel_in` is 0 in the cycle the opcode byte arrives, the whole frame is ignored.
- R6: If `prot_hit` is 1 in the cycle of the closing `frm_end`, nothing is written and `wip` stays 0.
- R7: After a commit is accepted, the array receives one write per loaded offset, in ascending offset order, over the 256 cycles that follow the frame end. The address of each write is {page, offset}. Offsets that were not loaded are not written.
- R8: `wip` goes high in the cycle after an accepted frame end and stays high for 256 + `BUSY_TICKS` cycles. `wel_clr` pulses once, in the last cycle of `wip`.
- R9: While `wip` is 1, received bytes and frame ends have no effect. A frame that is still open when `wip` falls is ignored up to its end.
- R10: If the first byte of a frame is anything other than 0x02, the frame is ignored up to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One received frame byte is on `rx_byte` this cycle |
| rx_byte | input | 8 | Received byte |
| frm_end | input | 1 | Chip select went inactive (one-cycle strobe) |
| frm_aligned | input | 1 | With `frm_end`: the bit count was a whole number of bytes |
| wel_in | input | 1 | Write-enable latch state |
| prot_hit | input | 1 | Target page falls in a protected region |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 17 | Array byte address |
| arr_data | output | 8 | Array write data |
| wip | output | 1 | Write cycle in progress, also blocks array reads |
| wel_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
The assertions assume that the decoder never raises `rx_valid` and `frm_end` in the same cycle, and that `frm_end` is a single-cycle pulse. The bench's byte and frame-end tasks hold each strobe for exactly one clock and never overlap them. The assertions also assume that `prot_hit` is already settled when the frame ends, so the bench sets it before the end strobe and keeps it steady until the frame is over. A behavioural model in the bench follows the same input stream and is compared with the outputs on every clock. That includes a frame deliberately sent across the falling edge of `wip`.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP,
        ST_COMMIT,
        ST_BUSY
    } pgw_state_e;

    localparam logic [7:0] OPC_PAGE_WRITE = 8'h02;
    localparam int         ADDR_BYTES     = 3;

endpackage

// File: rtl/pgw_busy_timer.sv
module pgw_busy_timer #(
    parameter int TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == LAST) begin
                cnt <= '0;
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = run && (cnt == LAST);

    // R8: the busy window never runs past its programmed length
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));

    // R8: expiry is reported once and the timer then stops
    assert_done_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !run);

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_vld
);
    localparam int DEPTH = 1 << OFF_W;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vld <= '0;
        else if (clr)    vld <= '0;
        else if (wr_en)  vld[wr_idx] <= 1'b1;
    end

    assign rd_data = mem[rd_idx];
    assign rd_vld  = vld[rd_idx];

    // R3: a new frame starts with an empty staging page
    assert_clr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld == '0));

    // R3: a loaded slot reads back as loaded
    assert_slot_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && (wr_idx == rd_idx)) |=> $past(wr_idx) != rd_idx || rd_vld);

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int OFF_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    frm_end,
    input  logic                    frm_aligned,
    input  logic                    wel_in,
    input  logic                    prot_hit,
    input  logic                    buf_vld,
    input  logic                    tmr_done,
    output logic                    buf_clr,
    output logic                    buf_wr,
    output logic [OFF_W-1:0]        wr_idx,
    output logic [OFF_W-1:0]        rd_idx,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic                    tmr_start,
    output logic                    commit_we,
    output logic                    wip,
    output logic                    wel_clr
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] SLOT_LAST = '1;
    localparam logic [1:0] ABYTE_LAST = 2'(ADDR_BYTES - 1);

    pgw_state_e      state, nxt;
    logic [15:0]     ashift;
    logic [1:0]      acnt;
    logic [OFF_W-1:0] ptr, slot;
    logic            loaded;
    logic            in_frame;
    logic            accept;
    logic [23:0]     addr_full;

    assign accept    = (rx_byte == OPC_PAGE_WRITE) && wel_in;
    assign addr_full = {ashift, rx_byte};

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (rx_valid) nxt = accept ? ST_ADDR : ST_SKIP;
            ST_ADDR: begin
                if (frm_end) nxt = ST_IDLE;
                else if (rx_valid && acnt == ABYTE_LAST) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (frm_end)
                    nxt = (frm_aligned && loaded && !prot_hit) ? ST_COMMIT : ST_IDLE;
            end
            ST_SKIP:   if (frm_end) nxt = ST_IDLE;
            ST_COMMIT: if (slot == SLOT_LAST) nxt = ST_BUSY;
            ST_BUSY: begin
                if (tmr_done) begin
                    if (frm_end)                    nxt = ST_IDLE;
                    else if (in_frame || rx_valid)  nxt = ST_SKIP;
                    else                            nxt = ST_IDLE;
                end
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ashift   <= '0;
            acnt     <= '0;
            ptr      <= '0;
            slot     <= '0;
            page     <= '0;
            loaded   <= 1'b0;
            in_frame <= 1'b0;
        end else begin
            if (frm_end)       in_frame <= 1'b0;
            else if (rx_valid) in_frame <= 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (rx_valid && accept) begin
                        acnt   <= '0;
                        loaded <= 1'b0;
                    end
                end
                ST_ADDR: begin
                    if (rx_valid && !frm_end) begin
                        ashift <= {ashift[7:0], rx_byte};
                        acnt   <= acnt + 1'b1;
                        if (acnt == ABYTE_LAST) begin
                            page <= addr_full[ADDR_W-1:OFF_W];
                            ptr  <= addr_full[OFF_W-1:0];
                        end
                    end
                end
                ST_DATA: begin
                    if (frm_end) begin
                        slot <= '0;
                    end else if (rx_valid) begin
                        ptr    <= ptr + 1'b1;
                        loaded <= 1'b1;
                    end
                end
                ST_COMMIT: slot <= slot + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        buf_clr   = (state == ST_IDLE) && rx_valid && accept;
        buf_wr    = (state == ST_DATA) && rx_valid && !frm_end;
        wr_idx    = ptr;
        rd_idx    = slot;
        tmr_start = (state == ST_COMMIT) && (slot == SLOT_LAST);
        commit_we = (state == ST_COMMIT) && buf_vld;
        wip       = (state == ST_COMMIT) || (state == ST_BUSY);
        wel_clr   = (state == ST_BUSY) && tmr_done;
    end

    // R4: a write cycle only starts after an aligned frame end
    assert_commit_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(frm_end && frm_aligned));

    // R6: a protected target never starts a write cycle
    assert_commit_unprotected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !$past(prot_hit));

    // R9: the staging page is untouched during the write cycle
    assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !(buf_wr || buf_clr));

endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
    parameter int ADDR_W     = 17,
    parameter int OFF_W      = 8,
    parameter int BUSY_TICKS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frm_end,
    input  logic              frm_aligned,
    input  logic              wel_in,
    input  logic              prot_hit,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    output logic              wip,
    output logic              wel_clr
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              buf_clr, buf_wr, buf_vld, tmr_start, tmr_done, commit_we;
    logic [OFF_W-1:0]  wr_idx, rd_idx;
    logic [PAGE_W-1:0] page;
    logic [7:0]        buf_q;

    pgw_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frm_end(frm_end), .frm_aligned(frm_aligned), .wel_in(wel_in),
        .prot_hit(prot_hit), .buf_vld(buf_vld), .tmr_done(tmr_done),
        .buf_clr(buf_clr), .buf_wr(buf_wr), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .page(page), .tmr_start(tmr_start), .commit_we(commit_we),
        .wip(wip), .wel_clr(wel_clr)
    );

    pgw_page_buf #(.OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(wr_idx), .wr_data(rx_byte), .rd_idx(rd_idx),
        .rd_data(buf_q), .rd_vld(buf_vld)
    );

    pgw_busy_timer #(.TICKS(BUSY_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
    );

    assign arr_we   = commit_we;
    assign arr_addr = {page, rd_idx};
    assign arr_data = buf_q;

    // R7: array writes happen only inside the write cycle
    assert_we_inside_wip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip);

    // R7: writes within one cycle go to strictly rising addresses
    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(wip) && $past(arr_we)) |-> (arr_addr > $past(arr_addr)));

    // R8: latch clear is the final cycle of the busy window
    assert_wclr_ends_wip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> wip ##1 !wip);

    // R1: quiet outputs right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!wip && !arr_we && !wel_clr));

endmodule

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;
    localparam int T = 40;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, frm_end = 0, frm_aligned = 0, wel_in = 0, prot_hit = 0;
    logic [7:0] rx_byte = 0;
    logic arr_we, wip, wel_clr;
    logic [16:0] arr_addr;
    logic [7:0] arr_data;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pgw_top #(.ADDR_W(17), .OFF_W(8), .BUSY_TICKS(T)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frm_end(frm_end), .frm_aligned(frm_aligned), .wel_in(wel_in),
        .prot_hit(prot_hit), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .wip(wip), .wel_clr(wel_clr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  ph = 0, nab = 0, mpage = 0, mptr = 0, mslot = 0, tcnt = 0;
    int  shreg = 0;
    bit  any = 0, inf = 0;
    bit [7:0] pbuf [256];
    bit  pv [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; inf = 0; any = 0;
        end else begin
            case (ph)
                0: if (rx_valid) begin
                       if (rx_byte == 8'h02 && wel_in) begin
                           ph = 1; nab = 0; any = 0;
                           foreach (pv[i]) pv[i] = 0;
                       end else ph = 3;
                   end
                1: if (frm_end) ph = 0;
                   else if (rx_valid) begin
                       shreg = ((shreg << 8) | rx_byte) & 24'hFFFFFF;
                       nab++;
                       if (nab == 3) begin
                           mpage = (shreg >> 8) & 511; mptr = shreg & 255; ph = 2;
                       end
                   end
                2: if (frm_end) begin
                       if (frm_aligned && any && !prot_hit) begin ph = 4; mslot = 0; end
                       else ph = 0;
                   end else if (rx_valid) begin
                       pbuf[mptr] = rx_byte; pv[mptr] = 1; any = 1;
                       mptr = (mptr + 1) % 256;
                   end
                3: if (frm_end) ph = 0;
                4: if (mslot == 255) begin ph = 5; tcnt = 0; end
                   else mslot++;
                5: if (tcnt == T - 1) begin
                       if (frm_end) ph = 0;
                       else if (inf || rx_valid) ph = 3;
                       else ph = 0;
                   end else tcnt++;
                default: ph = 0;
            endcase
            if (frm_end) inf = 0; else if (rx_valid) inf = 1;
        end
    end

    // per-cycle comparison away from the active edge
    logic [7:0] sink [int];
    int we_events = 0, wip_rises = 0, clr_pulses = 0, run = 0, last_run = 0;
    bit prev_wip = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ewe; bit ewip; bit eclr;
            ewip = (ph == 4 || ph == 5);
            ewe  = (ph == 4) && pv[mslot];
            eclr = (ph == 5) && (tcnt == T - 1);
            chk(wip == ewip, "R8 wip per cycle", wip, ewip);
            chk(wel_clr == eclr, "R8 wel_clr per cycle", wel_clr, eclr);
            chk(arr_we == ewe, "R7 arr_we per cycle", arr_we, ewe);
            if (ewe && arr_we) begin
                chk(arr_addr == 17'(mpage * 256 + mslot), "R7 arr_addr", arr_addr, mpage * 256 + mslot);
                chk(arr_data == pbuf[mslot], "R7 arr_data", arr_data, pbuf[mslot]);
            end
            if (arr_we) begin sink[int'(arr_addr)] = arr_data; we_events++; end
            if (wip && !prev_wip) begin wip_rises++; run = 0; end
            if (wip) run++;
            if (!wip && prev_wip) last_run = run;
            if (wel_clr) clr_pulses++;
            prev_wip = wip;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic end_frame(input bit al);
        @(negedge clk); frm_end = 1; frm_aligned = al;
        @(negedge clk); frm_end = 0; frm_aligned = 0;
    endtask

    function automatic logic [7:0] dval(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    task automatic frame(input logic [7:0] op, input logic [23:0] a, input int n,
                         input int seed, input bit al);
        send_byte(op);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
        for (int i = 0; i < n; i++) send_byte(dval(seed, i));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (wip) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- directed tests ----------------
    initial begin
        int we0, r0;
        repeat (3) @(negedge clk);
        chk(wip == 0 && arr_we == 0 && wel_clr == 0, "R1 reset outputs", {wip, arr_we, wel_clr}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(wip == 0 && arr_we == 0 && wel_clr == 0, "R1 after reset", {wip, arr_we, wel_clr}, 0);

        // R2 / R7 / R8: basic write, top address bits ignored
        wel_in = 1;
        frame(8'h02, 24'hFF2345, 3, 16, 1); end_frame(1);
        settle();
        for (int i = 0; i < 3; i++)
            chk(sink.exists(32'h12345 + i) && sink[32'h12345 + i] == dval(16, i),
                "R2 address and data", sink.exists(32'h12345 + i) ? sink[32'h12345 + i] : -1, dval(16, i));
        chk(!sink.exists(32'h12344) && !sink.exists(32'h12348), "R7 untouched neighbours", 1, 0);
        chk(we_events == 3, "R7 write count", we_events, 3);
        chk(last_run == 256 + T, "R8 wip length", last_run, 256 + T);
        chk(clr_pulses == 1, "R8 single wel_clr", clr_pulses, 1);

        // R3: wrap within page
        frame(8'h02, 24'h0002FE, 4, 50, 1); end_frame(1);
        settle();
        chk(sink[32'h2FE] == dval(50, 0) && sink[32'h2FF] == dval(50, 1), "R3 tail of page", sink[32'h2FF], dval(50, 1));
        chk(sink[32'h200] == dval(50, 2) && sink[32'h201] == dval(50, 3), "R3 wrap to page start", sink[32'h200], dval(50, 2));
        chk(!sink.exists(32'h300), "R3 next page untouched", 1, 0);

        // R3: overwrite after 258 bytes
        frame(8'h02, 24'h000410, 258, 3, 1); end_frame(1);
        settle();
        chk(sink[32'h410] == dval(3, 256), "R3 overwrite offset 0x10", sink[32'h410], dval(3, 256));
        chk(sink[32'h411] == dval(3, 257), "R3 overwrite offset 0x11", sink[32'h411], dval(3, 257));
        chk(sink[32'h412] == dval(3, 2), "R3 kept offset 0x12", sink[32'h412], dval(3, 2));

        // R4: unaligned end, address-phase end, empty frame
        we0 = we_events; r0 = wip_rises;
        frame(8'h02, 24'h000500, 5, 9, 1); end_frame(0); settle();
        frame(8'h02, 24'h000600, 0, 9, 1); end_frame(1); settle();
        send_byte(8'h02); send_byte(8'h00); end_frame(1); settle();
        chk(we_events == we0 && wip_rises == r0, "R4 no commit", we_events - we0, 0);

        // R5: latch clear at opcode
        wel_in = 0;
        send_byte(8'h02); wel_in = 1;
        send_byte(8'h00); send_byte(8'h07); send_byte(8'h00); send_byte(8'hAA);
        end_frame(1); settle();
        chk(!sink.exists(32'h700) && wip_rises == r0, "R5 frame ignored", wip_rises - r0, 0);

        // R6: protected target
        frame(8'h02, 24'h000800, 2, 1, 1); prot_hit = 1; end_frame(1); prot_hit = 0; settle();
        chk(!sink.exists(32'h800) && wip_rises == r0, "R6 protected", wip_rises - r0, 0);

        // R10: other opcode
        frame(8'h03, 24'h000900, 2, 1, 1); end_frame(1); settle();
        chk(!sink.exists(32'h900) && wip_rises == r0, "R10 other opcode", wip_rises - r0, 0);

        // R9: frames during busy and across its end
        frame(8'h02, 24'h000A00, 1, 77, 1); end_frame(1);
        frame(8'h02, 24'h000B00, 4, 5, 1); end_frame(1);
        repeat (200) @(negedge clk);
        frame(8'h02, 24'h000C00, 120, 5, 1); end_frame(1);
        settle();
        chk(sink[32'hA00] == dval(77, 0), "R9 first commit done", sink[32'hA00], dval(77, 0));
        chk(!sink.exists(32'hB00) && !sink.exists(32'hC00), "R9 busy frames ignored", 1, 0);
        chk(wip_rises == r0 + 1, "R9 single write cycle", wip_rises - r0, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule